// File: doc/BRIEF.md
# Hyperbolic CORDIC Natural Logarithm Unit

This block takes an unsigned fixed-point operand and returns its natural logarithm as a signed fixed-point number with 16 fractional bits. A leading-one search first splits the operand into a mantissa t in [0.5, 1) and a power-of-two exponent n. A hyperbolic CORDIC running in vectoring mode then drives the y coordinate of the pair (t+1, t−1) toward zero. The angle it accumulates is half of ln(t). The final step doubles that angle and adds n times a fixed ln 2 term.

A caller presents the operand together with a one-cycle `start` pulse. It then waits for a one-cycle `done` pulse, after which `lnOut` and `zeroErr` stay valid until the next `done`. A zero operand has no logarithm. For it the unit skips the iterations, raises `zeroErr` and returns the most negative output code.

Top module: `cordic_ln`

## Requirements
- R1: While reset is asserted and after it is released, `done`, `zeroErr` and `lnOut` are all 0 until the first result is produced.
- R2: `operand` is unsigned with IN_FRAC fractional bits, so its value is operand/2^IN_FRAC. `lnOut` is two's complement with 16 fractional bits, so its value is lnOut/65536.
- R3: For a nonzero operand whose highest set bit is at position p (bit 0 = LSB), the unit uses t = operand/2^(p+1) and n = p+1−IN_FRAC. Every power-of-two operand therefore yields ln(0.5) + n·ln 2.
- R4: For a nonzero operand, `lnOut` is within ±12 LSB of round(65536·ln t) + n·45423. The value 45423 is 0.6931 in Q16.
- R5: A `start` accepted while idle with a nonzero operand produces a single-cycle `done` exactly NUM_ITER+3 clock edges later (19 edges for 16 iterations). The extra edges come from the two repeated stages, at shifts 4 and 13, and from one output edge.
- R6: A `start` seen while a computation is in progress, or in the cycle that `done` is being produced, is ignored. It causes no extra `done` and leaves the result unchanged.
- R7: A zero operand gives `done` one edge after acceptance, with `zeroErr`=1 and `lnOut` = −2^(OUT_W−1).
- R8: `lnOut` and `zeroErr` hold their values between `done` pulses. `zeroErr` returns to 0 with the next nonzero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a computation on `operand` when idle |
| operand | input | IN_W | Unsigned fixed-point input, IN_FRAC fractional bits |
| done | output | 1 | One-cycle pulse marking a new result |
| lnOut | output | OUT_W | Signed Q16 natural logarithm |
| zeroErr | output | 1 | Set when the last operand was zero |

## Verification
The bench builds the unit with its defaults: a 16-bit operand with 8 fractional bits, a 32-bit output and 16 iterations. With these values every leading-one position from 0 to 15 can be reached, so the exponent sweeps from −7 to +8. Both repeated stages also fall inside the schedule. Powers of two, scattered operands, all-ones, zero, and starts held or pulsed during busy periods are each compared on every clock against a behavioural model of latency, value and hold behaviour.

// File: rtl/ln_pkg.sv
package ln_pkg;

  localparam int FIX_FRAC = 16;
  localparam int LN2_FIX  = 45423;   // 0.6931 in Q16
  localparam int REP_A    = 4;       // shift executed twice
  localparam int REP_B    = 13;      // shift executed twice

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_FIN  = 2'd2
  } lnState_t;

  typedef struct packed {
    logic load;
    logic iter;
    logic fin;
    logic zeroCase;
  } lnStrobe_t;

  // atanh(2^-i) in Q16
  function automatic int atanhFix(input int i);
    case (i)
      1: atanhFix = 35999;
      2: atanhFix = 16739;
      3: atanhFix = 8235;
      4: atanhFix = 4101;
      5: atanhFix = 2049;
      6: atanhFix = 1024;
      default: atanhFix = (i > FIX_FRAC || i < 1) ? 0 : (1 << (FIX_FRAC - i));
    endcase
  endfunction

  function automatic int stepCount(input int numIter);
    stepCount = numIter + ((numIter >= REP_A) ? 1 : 0) + ((numIter >= REP_B) ? 1 : 0);
  endfunction

endpackage

// File: rtl/ln_lead_one.sv
module ln_lead_one #(
  parameter int W  = 16,
  parameter int PW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic [PW-1:0] pos,
  output logic          found
);

  always_comb begin
    pos   = '0;
    found = 1'b0;
    for (int k = 0; k < W; k++) begin
      if (vec[k]) begin
        pos   = PW'(k);
        found = 1'b1;
      end
    end
  end

endmodule

// File: rtl/ln_ctrl.sv
module ln_ctrl
  import ln_pkg::*;
#(
  parameter int NUM_ITER = 16,
  parameter int SHW      = $clog2(NUM_ITER + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic           dinZero,
  output lnStrobe_t      strobe,
  output logic [SHW-1:0] shAmt,
  output logic           done
);

  localparam int STEPS = stepCount(NUM_ITER);
  localparam int STW   = $clog2(STEPS + 1);
  localparam logic [STW-1:0] LAST = STW'(STEPS - 1);

  lnState_t       state;
  logic [STW-1:0] step;
  logic           zeroLatch;
  int             shInt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      step      <= '0;
      zeroLatch <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= (state == S_FIN);
      case (state)
        S_IDLE: begin
          if (start) begin
            step      <= '0;
            zeroLatch <= dinZero;
            state     <= dinZero ? S_FIN : S_RUN;
          end
        end
        S_RUN: begin
          step <= step + 1'b1;
          if (step == LAST) state <= S_FIN;
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    shInt = int'(step) + 1;
    if (int'(step) >= REP_A)     shInt = shInt - 1;
    if (int'(step) >= REP_B + 1) shInt = shInt - 1;
    shAmt = SHW'(shInt);
  end

  always_comb begin
    strobe.load     = (state == S_IDLE) && start;
    strobe.iter     = (state == S_RUN);
    strobe.fin      = (state == S_FIN);
    strobe.zeroCase = zeroLatch;
  end

  // R5: result pulse is one cycle wide
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5: one iteration per clock until the last step
  a_r5_step_advance: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RUN && step != LAST) |=> (state == S_RUN && step == $past(step) + 1'b1));

  // R5: last iteration hands over to the output cycle
  a_r5_last_to_fin: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RUN && step == LAST) |=> (state == S_FIN));

  // R6: a busy unit never reloads
  a_r6_no_reload: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE) |-> !strobe.load);

endmodule

// File: rtl/ln_datapath.sv
module ln_datapath
  import ln_pkg::*;
#(
  parameter int IN_W     = 16,
  parameter int IN_FRAC  = 8,
  parameter int OUT_W    = 32,
  parameter int NUM_ITER = 16,
  parameter int SHW      = $clog2(NUM_ITER + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [IN_W-1:0]         din,
  input  lnStrobe_t               strobe,
  input  logic [SHW-1:0]          shAmt,
  output logic                    dinZero,
  output logic signed [OUT_W-1:0] lnOut,
  output logic                    zeroErr
);

  localparam int DW = FIX_FRAC + 4;
  localparam int PW = (IN_W > 1) ? $clog2(IN_W) : 1;
  localparam int NW = $clog2(IN_W + IN_FRAC + 1) + 1;
  localparam int WW = IN_W + FIX_FRAC;
  localparam logic signed [DW-1:0]    ONE   = DW'(1) <<< FIX_FRAC;
  localparam logic signed [DW-1:0]    TWO   = DW'(2) <<< FIX_FRAC;
  localparam logic signed [DW-1:0]    HALF  = DW'(1) <<< (FIX_FRAC - 1);
  localparam logic signed [OUT_W-1:0] LN2_Q = OUT_W'(LN2_FIX);
  localparam logic signed [OUT_W-1:0] MINV  = {1'b1, {(OUT_W-1){1'b0}}};

  logic [PW-1:0]          pos;
  logic                   found;
  logic [WW-1:0]          wide;
  logic signed [DW-1:0]   tS;
  logic signed [NW-1:0]   nNext;
  logic signed [DW-1:0]   xReg, yReg, zReg;
  logic signed [NW-1:0]   nReg;
  logic signed [DW-1:0]   xSh, ySh, ang;
  logic signed [OUT_W-1:0] zExt, nExt, lnVal;

  ln_lead_one #(.W(IN_W), .PW(PW)) u_lead (
    .vec  (din),
    .pos  (pos),
    .found(found)
  );

  assign dinZero = !found;

  // mantissa t in [0.5,1) with its top bit at FIX_FRAC-1
  always_comb begin
    wide  = ({{FIX_FRAC{1'b0}}, din} << (FIX_FRAC - 1)) >> pos;
    tS    = signed'(DW'(wide[FIX_FRAC-1:0]));
    nNext = NW'(int'(pos) + 1 - IN_FRAC);
  end

  always_comb begin
    xSh = xReg >>> shAmt;
    ySh = yReg >>> shAmt;
    ang = DW'(atanhFix(int'(shAmt)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xReg <= '0;
      yReg <= '0;
      zReg <= '0;
      nReg <= '0;
    end else if (strobe.load) begin
      xReg <= tS + ONE;
      yReg <= tS - ONE;
      zReg <= '0;
      nReg <= nNext;
    end else if (strobe.iter) begin
      if (yReg[DW-1]) begin
        xReg <= xReg + ySh;
        yReg <= yReg + xSh;
        zReg <= zReg - ang;
      end else begin
        xReg <= xReg - ySh;
        yReg <= yReg - xSh;
        zReg <= zReg + ang;
      end
    end
  end

  always_comb begin
    zExt  = OUT_W'(zReg);
    nExt  = OUT_W'(nReg);
    lnVal = (zExt <<< 1) + nExt * LN2_Q;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lnOut   <= '0;
      zeroErr <= 1'b0;
    end else if (strobe.fin) begin
      lnOut   <= strobe.zeroCase ? MINV : lnVal;
      zeroErr <= strobe.zeroCase;
    end
  end

  // R3: loaded pair is (t+1, t-1) with t in [0.5,1)
  a_r3_load_norm: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && found) |=> ((xReg - yReg) == TWO && yReg[DW-1] && yReg >= -HALF));

  // R4: vectoring has driven y close to zero before the output cycle
  a_r4_y_settled: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fin && !strobe.zeroCase) |-> (yReg < DW'(64) && yReg > -DW'(64)));

  // R7: error flag always pairs with the most negative code
  a_r7_zero_min: assert property (@(posedge clk) disable iff (!rstN)
    zeroErr |-> (lnOut == MINV));

  // R8: outputs move only on the output cycle
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.fin |=> ($stable(lnOut) && $stable(zeroErr)));

endmodule

// File: rtl/cordic_ln.sv
module cordic_ln
  import ln_pkg::*;
#(
  parameter int IN_W     = 16,
  parameter int IN_FRAC  = 8,
  parameter int OUT_W    = 32,
  parameter int NUM_ITER = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [IN_W-1:0]  operand,
  output logic             done,
  output logic [OUT_W-1:0] lnOut,
  output logic             zeroErr
);

  localparam int SHW = $clog2(NUM_ITER + 1);

  lnStrobe_t               strobe;
  logic [SHW-1:0]          shAmt;
  logic                    dinZero;
  logic signed [OUT_W-1:0] lnInt;

  ln_ctrl #(.NUM_ITER(NUM_ITER), .SHW(SHW)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .dinZero(dinZero),
    .strobe (strobe),
    .shAmt  (shAmt),
    .done   (done)
  );

  ln_datapath #(
    .IN_W(IN_W), .IN_FRAC(IN_FRAC), .OUT_W(OUT_W), .NUM_ITER(NUM_ITER), .SHW(SHW)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .din    (operand),
    .strobe (strobe),
    .shAmt  (shAmt),
    .dinZero(dinZero),
    .lnOut  (lnInt),
    .zeroErr(zeroErr)
  );

  assign lnOut = lnInt;

endmodule

// File: tb/cordic_ln_tb.sv
`timescale 1ns/1ps
module cordic_ln_tb;

  localparam int IN_W     = 16;
  localparam int IN_FRAC  = 8;
  localparam int OUT_W    = 32;
  localparam int NUM_ITER = 16;
  localparam int LAT      = NUM_ITER + 3;
  localparam int TOL      = 12;
  localparam int WDOG     = 100000;
  localparam longint MINV = -(longint'(1) << (OUT_W - 1));

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [IN_W-1:0]  operand = '0;
  logic             done;
  logic [OUT_W-1:0] lnOut;
  logic             zeroErr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  string doneTag = "R5";
  string valTag  = "R4";

  // reference model state
  int     cnt = 0;
  bit     expDone = 1'b0;
  longint pendExp = 0;
  bit     pendErr = 1'b0;
  longint holdExp = 0;
  bit     holdErr = 1'b0;
  bit     haveRes = 1'b0;
  longint lastRes = 0;

  cordic_ln #(.IN_W(IN_W), .IN_FRAC(IN_FRAC), .OUT_W(OUT_W), .NUM_ITER(NUM_ITER)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .operand(operand),
    .done(done), .lnOut(lnOut), .zeroErr(zeroErr)
  );

  always #2 clk = ~clk;

  function automatic longint refLn(input logic [IN_W-1:0] v);
    int  p = 0;
    real t;
    int  n;
    for (int k = 0; k < IN_W; k++) if (v[k]) p = k;
    t = real'(v) / (2.0 ** (p + 1));
    n = p + 1 - IN_FRAC;
    refLn = longint'($ln(t) * 65536.0) + longint'(n) * 45423;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // behavioural model, one step per clock
  always @(posedge clk) begin
    cyc++;
    expDone = 1'b0;
    if (!rstN) cnt = 0;
    else if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin
        expDone = 1'b1;
        holdExp = pendExp;
        holdErr = pendErr;
      end
    end else if (start) begin
      if (operand == '0) begin
        cnt = 1; pendErr = 1'b1; pendExp = MINV;
      end else begin
        cnt = LAT; pendErr = 1'b0; pendExp = refLn(operand);
      end
    end
    if (cyc > WDOG && !finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      longint r;
      r = longint'($signed(lnOut));
      chk(done === expDone, doneTag, "done", longint'(done), longint'(expDone));
      if (expDone) begin
        chk(zeroErr === holdErr, holdErr ? "R7" : "R8", "zeroErr", longint'(zeroErr), longint'(holdErr));
        if (holdErr)
          chk(r == MINV, "R7", "lnOut zero", r, MINV);
        else
          chk((r - holdExp) <= TOL && (holdExp - r) <= TOL, valTag, "lnOut", r, holdExp);
        haveRes = 1'b1;
        lastRes = r;
      end else if (haveRes) begin
        chk(r == lastRes && zeroErr === holdErr, "R8", "hold", r, lastRes);
      end
    end
  end

  task automatic runOne(input logic [IN_W-1:0] v);
    @(negedge clk);
    operand = v;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (LAT + 3) @(negedge clk);
  endtask

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    // R1: reset values while reset held
    chk(done === 1'b0 && zeroErr === 1'b0 && lnOut === '0, "R1", "reset", longint'(lnOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(done === 1'b0 && zeroErr === 1'b0 && lnOut === '0, "R1", "after reset", longint'(lnOut), 0);
    repeat (3) @(negedge clk);

    // R3: every leading-one position
    valTag = "R3";
    for (int k = 0; k < IN_W; k++) runOne(IN_W'(1) << k);

    // R2: format anchors: 1.0, 10.0, 0.5, all ones, smallest
    valTag = "R2";
    runOne(16'h0100);
    runOne(16'h0A00);
    runOne(16'h0080);
    runOne(16'hFFFF);
    runOne(16'h0001);

    // R4: scattered operands
    valTag = "R4";
    lfsr = 32'h1234_5678;
    for (int k = 0; k < 40; k++) begin
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      runOne((lfsr[31:16] == 16'h0) ? 16'h0001 : lfsr[31:16]);
    end

    // R7: zero, then recovery (R8), then zeros back to back
    runOne(16'h0000);
    valTag = "R8";
    runOne(16'h0300);
    runOne(16'h0000);
    runOne(16'h0000);
    valTag = "R4";
    runOne(16'h7FFF);

    // R6: start pulsed while busy, then held high across runs
    doneTag = "R6";
    @(negedge clk);
    operand = 16'h0C35; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    operand = 16'h0002; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (LAT) @(negedge clk);
    for (int k = 0; k < 3 * (LAT + 1); k++) begin
      operand = IN_W'(16'h0111 * (k + 1));
      start = 1'b1;
      @(negedge clk);
    end
    start = 1'b0;
    repeat (LAT + 3) @(negedge clk);

    // R8: long idle with operand changing
    doneTag = "R5";
    for (int k = 0; k < 10; k++) begin
      operand = IN_W'(k * 16'h1357);
      @(negedge clk);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule